// File: doc/BRIEF.md
# Per-Byte Multi-Rotate Field Extractor

This block takes a vector of 64-bit data lanes and, for each lane, a 64-bit word of eight byte-wide offsets. Every byte of a lane's result is an 8-bit window cut from that lane. The window begins at the bit named by that byte's own offset and wraps past bit 63 back to bit 0, so the eight bytes of a result can come from eight unrelated places in the same word. The operation suits bit-field unpacking, where several packed fields of arbitrary alignment are pulled into byte slots in one step.

The datapath is combinational and ends in one register stage. A result is loaded when the input strobe is high and appears one clock later with its own strobe. Data and offsets are treated as raw bits. A parameter sets the number of lanes.

Top module: `multi_rotate_extract`

## Requirements
- R1: Bit k (0..7) of result byte j of lane i equals bit ((s + k) mod 64) of data lane i, where s is the offset held in index byte j of lane i.
- R2: Windows that run past bit 63 wrap to bit 0. With an offset of 59, the result byte holds, from its least significant bit upward, data bits 59, 60, 61, 62, 63, 0, 1, 2.
- R3: Only the low 6 bits of each offset are used, so offsets of 64 and above give the same result as the offset modulo 64.
- R4: Each of the eight bytes in a lane takes its window independently. Changing one byte's offset changes no other byte of the result.
- R5: Lane i occupies bits [64i+63:64i] of the data, index and result buses. Within a lane, index byte j sits at bits [8j+7:8j] and drives result byte j at bits [8j+7:8j].
- R6: `out_valid` equals `in_valid` from the previous clock. An active-low asynchronous reset clears `out_valid` and `out_result` to zero.
- R7: While `in_valid` is low, `out_result` keeps its previous value whatever the data and index inputs do.
- R8: Each lane is computed from its own data and index words only. The other lanes have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector is valid this cycle |
| in_data | input | LANES*64 | Data lanes, lane i at bits [64i+63:64i] |
| in_index | input | LANES*64 | Eight offset bytes for each lane |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| out_result | output | LANES*64 | Extracted byte windows for each lane |

## Verification
The bench aims at the wrap boundary with offsets 55, 56, 59 and 63. A design that shifts without rotating would fill the upper window bits with zeros there. Offsets of 64, 128 and 255 catch a design that uses too many offset bits, which would then return zero or the wrong window. Bytes with distinct offsets and lanes with different data catch byte or lane cross-talk and swapped field positions. Idle cycles with changing inputs catch a register that loads without a strobe, and a strobe that is dropped or delayed by a cycle.

// File: rtl/mre_pkg.sv
package mre_pkg;
    localparam int LANE_W   = 64;
    localparam int BYTE_W   = 8;
    localparam int BYTES    = LANE_W / BYTE_W;
    localparam int OFF_BITS = $clog2(LANE_W);
endpackage

// File: rtl/mre_byte_window.sv
module mre_byte_window
    import mre_pkg::*;
(
    input  logic [LANE_W-1:0] word_i,
    input  logic [BYTE_W-1:0] offset_i,
    output logic [BYTE_W-1:0] window_o
);
    logic [OFF_BITS-1:0] base;

    always_comb begin
        base = offset_i[OFF_BITS-1:0];
        for (int k = 0; k < BYTE_W; k++) begin
            window_o[k] = word_i[base + OFF_BITS'(k)];
        end
    end

    // R2: an offset of 59 must show five top bits then three bottom bits
    always_comb begin
        if (offset_i[OFF_BITS-1:0] == OFF_BITS'(59)) begin
            wrap_window_chk: assert (window_o == {word_i[2:0], word_i[63:59]});
        end
    end
endmodule

// File: rtl/mre_lane.sv
module mre_lane
    import mre_pkg::*;
(
    input  logic [LANE_W-1:0] word_i,
    input  logic [LANE_W-1:0] offsets_i,
    output logic [LANE_W-1:0] result_o
);
    for (genvar j = 0; j < BYTES; j++) begin : g_byte
        mre_byte_window u_win (
            .word_i   (word_i),
            .offset_i (offsets_i[j*BYTE_W +: BYTE_W]),
            .window_o (result_o[j*BYTE_W +: BYTE_W])
        );
    end

    logic [LANE_W-1:0] ident_offsets;
    always_comb begin
        for (int j = 0; j < BYTES; j++) begin
            ident_offsets[j*BYTE_W +: BYTE_W] = BYTE_W'(j * BYTE_W);
        end
    end

    // R5: offsets 8j in byte j must rebuild the lane unchanged
    always_comb begin
        if (offsets_i == ident_offsets) begin
            lane_identity_chk: assert (result_o == word_i);
        end
    end
endmodule

// File: rtl/multi_rotate_extract.sv
module multi_rotate_extract
    import mre_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*LANE_W-1:0] in_data,
    input  logic [LANES*LANE_W-1:0] in_index,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] out_result
);
    localparam int BUS_W = LANES * LANE_W;

    logic [BUS_W-1:0] comb_result;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        mre_lane u_lane (
            .word_i    (in_data[i*LANE_W +: LANE_W]),
            .offsets_i (in_index[i*LANE_W +: LANE_W]),
            .result_o  (comb_result[i*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result <= '0;
        end else if (in_valid) begin
            out_result <= comb_result;
        end
    end

    // R6
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R6
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));
endmodule

// File: tb/sim_multi_rotate_extract.sv
module sim_multi_rotate_extract;
    import mre_pkg::*;
    localparam int LANES = 2;
    localparam int BUS_W = LANES * LANE_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [BUS_W-1:0] in_data = '0;
    logic [BUS_W-1:0] in_index = '0;
    logic             out_valid;
    logic [BUS_W-1:0] out_result;

    always #2.5 clk = ~clk;

    multi_rotate_extract #(.LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_data(in_data), .in_index(in_index),
        .out_valid(out_valid), .out_result(out_result)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic             exp_v = 1'b0;
    logic [BUS_W-1:0] exp_r = '0;
    string            exp_tag = "R6";

    function automatic logic [BUS_W-1:0] model(logic [BUS_W-1:0] d, logic [BUS_W-1:0] x);
        logic [BUS_W-1:0] r = '0;
        for (int i = 0; i < LANES; i++) begin
            logic [63:0] w = d[i*64 +: 64];
            for (int j = 0; j < 8; j++) begin
                int s = x[i*64 + j*8 +: 8] % 64;
                logic [63:0] rot = (w >> s) | (w << (64 - s));
                r[i*64 + j*8 +: 8] = rot[7:0];
            end
        end
        return r;
    endfunction

    task automatic compare();
        n_vec++;
        if (out_valid !== exp_v || out_result !== exp_r) begin
            n_bad++;
            $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
                     exp_tag, out_valid, out_result, exp_v, exp_r);
        end
    endtask

    // check the previous step's outputs, then drive the next one
    task automatic step(logic v, logic [BUS_W-1:0] d, logic [BUS_W-1:0] x, string tag);
        @(negedge clk);
        compare();
        in_valid = v; in_data = d; in_index = x;
        exp_v = v;
        if (v) exp_r = model(d, x);
        exp_tag = tag;
    endtask

    function automatic logic [63:0] same_off(int s);
        logic [63:0] r;
        for (int j = 0; j < 8; j++) r[j*8 +: 8] = 8'(s);
        return r;
    endfunction

    localparam logic [63:0] PAT_A = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] PAT_B = 64'hF00D_CAFE_DEAD_BEEF;

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare();                  // R6 reset state
        rst_n = 1'b1;
        // R1 basic offsets
        step(1, {PAT_B, PAT_A}, {same_off(0), same_off(7)}, "R1");
        step(1, {PAT_A, PAT_B}, {64'h2818_100F_0A05_0301, 64'h0B0D_1113_1F25_2A33}, "R1");
        // R2 wrap boundary
        step(1, {PAT_B, PAT_A}, {same_off(55), same_off(56)}, "R2");
        step(1, {PAT_A, PAT_B}, {same_off(59), same_off(63)}, "R2");
        step(1, {64'h8000_0000_0000_0001, 64'h7}, {same_off(63), same_off(59)}, "R2");
        // R3 aliasing above 63
        step(1, {PAT_B, PAT_A}, {same_off(64), same_off(255)}, "R3");
        step(1, {PAT_A, PAT_B}, {same_off(128 + 59), same_off(64 + 5)}, "R3");
        // R4 independent bytes
        step(1, {PAT_A, PAT_B}, {64'h3F00_3F00_3F00_3F00, 64'h0001_0203_3C3D_3E3F}, "R4");
        // R5 field positions: identity offsets and reversed
        step(1, {PAT_B, PAT_A}, {64'h3830_2820_1810_0800, 64'h0008_1018_2028_3038}, "R5");
        // R6 idle gaps
        step(0, {PAT_A, PAT_A}, '0, "R6");
        step(1, {PAT_B, PAT_B}, {same_off(3), same_off(60)}, "R6");
        // R7 inputs change while idle
        step(0, {PAT_B, PAT_A}, {same_off(9), same_off(9)}, "R7");
        step(0, {PAT_A, PAT_B}, {same_off(41), same_off(2)}, "R7");
        // R8 one lane zero, the other busy
        step(1, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, {same_off(12), same_off(12)}, "R8");
        step(1, {PAT_A, 64'h0}, {same_off(61), same_off(61)}, "R8");
        for (int t = 0; t < 400; t++) begin
            step(1'($urandom_range(0, 3) != 0),
                 {$urandom, $urandom, $urandom, $urandom},
                 {$urandom, $urandom, $urandom, $urandom}, "R1");
        end
        step(0, '0, '0, "R6");
        @(negedge clk);
        compare();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule